// File: doc/BRIEF.md
# UART Control, Status and Interrupt Register Block

This block is the register file of a memory-mapped serial port. It holds four 16-bit control words, a FIFO control word, two baud words, a millisecond word and two status words. The block also folds the status bits and their enables into one registered interrupt line. Software reaches the registers through a word index with a write strobe and a combinational read port. The transmit and receive datapaths report events by pulsing per-bit set and clear vectors against the two status words. The serializer, the deserializer and the FIFO storage sit outside this block.

The status words mix read-only levels with sticky event flags. A write of one clears only the sticky flags, and every other written bit is dropped. A write to control word 1 with its bit 0 at zero acts as a soft reset. Writing a byte to the transmit slot with transmit enabled hands the byte to the datapath, and transmit-ready and transmit-done read as zero for that one cycle.

Top module: `uart_csr_block`

## Requirements
- R1: After reset the reads are ctl0=0x0000, ctl1=0x0001, ctl2=0x0700, ctl3=0x0000, fifo=0x0801, baud-mod=0x0000, baud-count=0x0004, ms=0x0000, status A=0x6040, status B=0x4028, test=0x0060, and irq=0. The word indices are tx 0x10, ctl0..ctl3 0x20..0x23, fifo 0x24, status A 0x25, status B 0x26, baud-mod 0x2A, baud-count 0x2B, ms 0x2C and test 0x2D.
- R2: Writes to the control, fifo, baud and ms words keep only wr_data[15:0], so the upper read bits are zero.
- R3: Writing status A clears only the bits set in both wr_data and 0x9DB0 (bits 15,12,11,10,8,7,5,4). Its other bits keep their value.
- R4: Writing status B clears only the bits set in both wr_data and 0xBBD6 (bits 15,13,12,11,9,8,7,6,4,2,1). Its other bits keep their value.
- R5: A pulse on hw_set_a or hw_set_b sets those status bits on the next edge. When a software clear of the same bit lands in the same cycle, the set wins.
- R6: A pulse on hw_clr_a or hw_clr_b clears those status bits, unless the same bit is set in that cycle.
- R7: Status A bit 13 (tx ready) and bit 9 (rx ready) raise irq only when the same bit of ctl0 is set.
- R8: Status B bit 14 (tx FIFO empty) raises irq only when ctl0 bit 6 is set.
- R9: Status B bits 0 (rx data), 1 (overrun), 3 (tx done) and 7 (wake) raise irq only when the same bit of ctl3 is set. No other status B bit reaches irq.
- R10: irq is registered. It reflects the status and enables one clock after they change.
- R11: A write to ctl1 with bit 0 at zero returns ctl0, ctl2, fifo, the baud words and both status words to their R1 values. ctl1 stores the written value with bit 0 forced to one, and ctl3 and ms keep their values.
- R12: A write to the tx slot while ctl1 bit 2 is set pulses tx_valid for one cycle with tx_byte=wr_data[7:0]. In that cycle status A bit 13 and status B bit 3 read zero, and the next cycle they read one again. With ctl1 bit 2 clear, the write does nothing.
- R13: Undefined indices read zero, and writes to them change nothing. The test word is read-only, with bit 6 equal to status B bit 14 and bit 5 equal to the inverse of status B bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | IDX_W | Word index for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Combinational read data for reg_idx |
| hw_set_a | input | 16 | Datapath set pulses for status A |
| hw_clr_a | input | 16 | Datapath clear pulses for status A |
| hw_set_b | input | 16 | Datapath set pulses for status B |
| hw_clr_b | input | 16 | Datapath clear pulses for status B |
| irq | output | 1 | Registered interrupt request |
| tx_valid | output | 1 | One-cycle strobe for an accepted transmit byte |
| tx_byte | output | DATA_W | Byte last accepted for transmit |

## Verification
Each interrupt source is exercised on its own. The bench first raises the status bit with its enable clear, then sets the enable, then drops the status again. This separates a wrong enable pairing from a missing term or an unregistered path. The clear masks are tested with all status bits set and an all-ones write, so every bit that is cleared by mistake or left set by mistake shows up in the read-back. A set and a clear of the same bit in one cycle checks the priority between them. A soft reset issued after a spread of non-default writes shows which words are reset and which are kept.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int unsigned CSR_W  = 16;
    localparam int unsigned TXD_W  = 8;

    // word indices (software-visible layout)
    localparam int unsigned IDX_TX    = 'h10;
    localparam int unsigned IDX_CTL0  = 'h20;
    localparam int unsigned IDX_CTL1  = 'h21;
    localparam int unsigned IDX_CTL2  = 'h22;
    localparam int unsigned IDX_CTL3  = 'h23;
    localparam int unsigned IDX_FIFO  = 'h24;
    localparam int unsigned IDX_STA   = 'h25;
    localparam int unsigned IDX_STB   = 'h26;
    localparam int unsigned IDX_BMOD  = 'h2A;
    localparam int unsigned IDX_BCNT  = 'h2B;
    localparam int unsigned IDX_MS    = 'h2C;
    localparam int unsigned IDX_TEST  = 'h2D;

    // bit positions that neighbouring logic depends on
    localparam int unsigned STA_TXRDY   = 13;
    localparam int unsigned STA_RXRDY   = 9;
    localparam int unsigned STB_TXFE    = 14;
    localparam int unsigned STB_TXDC    = 3;
    localparam int unsigned STB_RDR     = 0;
    localparam int unsigned CTL0_TXE_EN = 6;
    localparam int unsigned CTL1_SRST_N = 0;
    localparam int unsigned CTL1_TXEN   = 2;
    localparam int unsigned TEST_RXMT   = 5;
    localparam int unsigned TEST_TXMT   = 6;

    localparam logic [CSR_W-1:0] W1C_A   = 16'h9DB0;
    localparam logic [CSR_W-1:0] W1C_B   = 16'hBBD6;
    localparam logic [CSR_W-1:0] ALIGN_A = 16'h2200;
    localparam logic [CSR_W-1:0] ALIGN_B = 16'h008B;

    localparam logic [CSR_W-1:0] RST_STA  = 16'h6040;
    localparam logic [CSR_W-1:0] RST_STB  = 16'h4028;
    localparam logic [CSR_W-1:0] RST_CTL1 = 16'h0001;
    localparam logic [CSR_W-1:0] RST_CTL2 = 16'h0700;
    localparam logic [CSR_W-1:0] RST_FIFO = 16'h0801;
    localparam logic [CSR_W-1:0] RST_BCNT = 16'h0004;

    typedef struct packed {
        logic [CSR_W-1:0] ctl0;
        logic [CSR_W-1:0] ctl1;
        logic [CSR_W-1:0] ctl2;
        logic [CSR_W-1:0] ctl3;
        logic [CSR_W-1:0] fifo;
        logic [CSR_W-1:0] bmod;
        logic [CSR_W-1:0] bcnt;
        logic [CSR_W-1:0] ms;
        logic [CSR_W-1:0] sta;
        logic [CSR_W-1:0] stb;
        logic             tx_pend;
        logic [TXD_W-1:0] tx_byte;
        logic             irq;
    } csr_state_t;

    typedef struct packed {
        logic tx;
        logic ctl0;
        logic ctl1;
        logic ctl2;
        logic ctl3;
        logic fifo;
        logic sta;
        logic stb;
        logic bmod;
        logic bcnt;
        logic ms;
        logic known;
    } csr_sel_t;

    function automatic csr_state_t csr_reset_state();
        csr_state_t s;
        s         = '0;
        s.ctl1    = RST_CTL1;
        s.ctl2    = RST_CTL2;
        s.fifo    = RST_FIFO;
        s.bcnt    = RST_BCNT;
        s.sta     = RST_STA;
        s.stb     = RST_STB;
        return s;
    endfunction

endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode
    import uart_csr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    output csr_sel_t         wsel
);

    always_comb begin
        wsel = '0;
        if (wr_en) begin
            case (idx)
                IDX_W'(IDX_TX):   wsel.tx   = 1'b1;
                IDX_W'(IDX_CTL0): wsel.ctl0 = 1'b1;
                IDX_W'(IDX_CTL1): wsel.ctl1 = 1'b1;
                IDX_W'(IDX_CTL2): wsel.ctl2 = 1'b1;
                IDX_W'(IDX_CTL3): wsel.ctl3 = 1'b1;
                IDX_W'(IDX_FIFO): wsel.fifo = 1'b1;
                IDX_W'(IDX_STA):  wsel.sta  = 1'b1;
                IDX_W'(IDX_STB):  wsel.stb  = 1'b1;
                IDX_W'(IDX_BMOD): wsel.bmod = 1'b1;
                IDX_W'(IDX_BCNT): wsel.bcnt = 1'b1;
                IDX_W'(IDX_MS):   wsel.ms   = 1'b1;
                default:          wsel      = '0;
            endcase
            // test word is a known index but accepts no write
            wsel.known = (wsel != '0) || (idx == IDX_W'(IDX_TEST));
        end
    end

endmodule

// File: rtl/uart_csr_rdmux.sv
module uart_csr_rdmux
    import uart_csr_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int BUS_W = 32
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [CSR_W-1:0] ctl0,
    input  logic [CSR_W-1:0] ctl1,
    input  logic [CSR_W-1:0] ctl2,
    input  logic [CSR_W-1:0] ctl3,
    input  logic [CSR_W-1:0] fifo,
    input  logic [CSR_W-1:0] bmod,
    input  logic [CSR_W-1:0] bcnt,
    input  logic [CSR_W-1:0] ms,
    input  logic [CSR_W-1:0] sta,
    input  logic [CSR_W-1:0] stb,
    output logic [BUS_W-1:0] rd_data
);

    logic [CSR_W-1:0] test_w;
    logic [CSR_W-1:0] word;

    always_comb begin
        test_w            = '0;
        test_w[TEST_TXMT] = stb[STB_TXFE];
        test_w[TEST_RXMT] = ~stb[STB_RDR];
    end

    always_comb begin
        case (idx)
            IDX_W'(IDX_CTL0): word = ctl0;
            IDX_W'(IDX_CTL1): word = ctl1;
            IDX_W'(IDX_CTL2): word = ctl2;
            IDX_W'(IDX_CTL3): word = ctl3;
            IDX_W'(IDX_FIFO): word = fifo;
            IDX_W'(IDX_STA):  word = sta;
            IDX_W'(IDX_STB):  word = stb;
            IDX_W'(IDX_BMOD): word = bmod;
            IDX_W'(IDX_BCNT): word = bcnt;
            IDX_W'(IDX_MS):   word = ms;
            IDX_W'(IDX_TEST): word = test_w;
            default:          word = '0;
        endcase
        rd_data = BUS_W'(word);
    end

endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq
    import uart_csr_pkg::*;
(
    input  logic [CSR_W-1:0] sta,
    input  logic [CSR_W-1:0] stb,
    input  logic [CSR_W-1:0] ctl0,
    input  logic [CSR_W-1:0] ctl3,
    output logic             irq_req
);

    logic [CSR_W-1:0] en_b;
    logic [CSR_W-1:0] term_a;
    logic [CSR_W-1:0] term_b;

    always_comb begin
        en_b = ctl3 & ALIGN_B;
        en_b[STB_TXFE] = ctl0[CTL0_TXE_EN];
    end

    for (genvar i = 0; i < CSR_W; i++) begin : g_term
        if (ALIGN_A[i]) begin : g_a
            assign term_a[i] = sta[i] & ctl0[i];
        end else begin : g_a_off
            assign term_a[i] = 1'b0;
        end
        assign term_b[i] = stb[i] & en_b[i];
    end

    assign irq_req = (|term_a) | (|term_b);

endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
    import uart_csr_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int BUS_W  = 32,
    parameter int DATA_W = TXD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    input  logic [CSR_W-1:0]  hw_set_a,
    input  logic [CSR_W-1:0]  hw_clr_a,
    input  logic [CSR_W-1:0]  hw_set_b,
    input  logic [CSR_W-1:0]  hw_clr_b,
    output logic              irq,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte
);

    localparam csr_state_t ST_RST = csr_reset_state();

    csr_state_t       st_d, st_q;
    csr_sel_t         wsel;
    logic             irq_req;
    logic [CSR_W-1:0] wlo;
    logic             tx_fire;
    logic             srst_fire;
    logic             unused_hi;

    assign wlo       = wr_data[CSR_W-1:0];
    assign unused_hi = ^wr_data;

    uart_csr_decode #(.IDX_W(IDX_W)) u_dec (
        .idx   (reg_idx),
        .wr_en (wr_en),
        .wsel  (wsel)
    );

    uart_csr_irq u_irq (
        .sta     (st_q.sta),
        .stb     (st_q.stb),
        .ctl0    (st_q.ctl0),
        .ctl3    (st_q.ctl3),
        .irq_req (irq_req)
    );

    uart_csr_rdmux #(.IDX_W(IDX_W), .BUS_W(BUS_W)) u_rd (
        .idx     (reg_idx),
        .ctl0    (st_q.ctl0),
        .ctl1    (st_q.ctl1),
        .ctl2    (st_q.ctl2),
        .ctl3    (st_q.ctl3),
        .fifo    (st_q.fifo),
        .bmod    (st_q.bmod),
        .bcnt    (st_q.bcnt),
        .ms      (st_q.ms),
        .sta     (st_q.sta),
        .stb     (st_q.stb),
        .rd_data (rd_data)
    );

    assign tx_fire   = wsel.tx & st_q.ctl1[CTL1_TXEN];
    assign srst_fire = wsel.ctl1 & ~wlo[CTL1_SRST_N];

    always_comb begin
        st_d         = st_q;
        st_d.tx_pend = 1'b0;
        st_d.irq     = irq_req;

        // software write-one-to-clear on sticky flags only
        if (wsel.sta) st_d.sta = st_d.sta & ~(wlo & W1C_A);
        if (wsel.stb) st_d.stb = st_d.stb & ~(wlo & W1C_B);

        // datapath events: clear first, set wins
        st_d.sta = (st_d.sta & ~hw_clr_a) | hw_set_a;
        st_d.stb = (st_d.stb & ~hw_clr_b) | hw_set_b;

        // end of the transmit handoff cycle
        if (st_q.tx_pend) begin
            st_d.sta[STA_TXRDY] = 1'b1;
            st_d.stb[STB_TXDC]  = 1'b1;
        end

        if (wsel.ctl0) st_d.ctl0 = wlo;
        if (wsel.ctl2) st_d.ctl2 = wlo;
        if (wsel.ctl3) st_d.ctl3 = wlo;
        if (wsel.fifo) st_d.fifo = wlo;
        if (wsel.bmod) st_d.bmod = wlo;
        if (wsel.bcnt) st_d.bcnt = wlo;
        if (wsel.ms)   st_d.ms   = wlo;

        if (tx_fire) begin
            st_d.tx_pend        = 1'b1;
            st_d.tx_byte        = wr_data[TXD_W-1:0];
            st_d.sta[STA_TXRDY] = 1'b0;
            st_d.stb[STB_TXDC]  = 1'b0;
        end

        if (wsel.ctl1) begin
            if (srst_fire) begin
                st_d.ctl0    = ST_RST.ctl0;
                st_d.ctl2    = ST_RST.ctl2;
                st_d.fifo    = ST_RST.fifo;
                st_d.bmod    = ST_RST.bmod;
                st_d.bcnt    = ST_RST.bcnt;
                st_d.sta     = ST_RST.sta;
                st_d.stb     = ST_RST.stb;
                st_d.tx_pend = 1'b0;
            end
            st_d.ctl1 = wlo;
            st_d.ctl1[CTL1_SRST_N] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign irq      = st_q.irq;
    assign tx_valid = st_q.tx_pend;
    assign tx_byte  = DATA_W'(st_q.tx_byte);

    AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |=> (!st_q.sta[STA_TXRDY] && !st_q.stb[STB_TXDC] && tx_valid)); // R12

    AST_TX_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tx_pend && !tx_fire) |=> (st_q.sta[STA_TXRDY] && st_q.stb[STB_TXDC] && !tx_valid)); // R12

    AST_SRST_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fire |=> (st_q.sta == RST_STA && st_q.stb == RST_STB && st_q.ctl1[CTL1_SRST_N])); // R11

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctl0 == '0 && st_q.ctl3 == '0) |=> !irq); // R7

    AST_RO_A_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel.sta && hw_set_a == '0 && hw_clr_a == '0 && !st_q.tx_pend)
        |=> ((st_q.sta & ~W1C_A) == $past(st_q.sta & ~W1C_A))); // R3

    AST_UNKNOWN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wsel.known)
        |=> (st_q.ctl0 == $past(st_q.ctl0) && st_q.ctl1 == $past(st_q.ctl1)
             && st_q.ms == $past(st_q.ms) && !tx_valid)); // R13

endmodule

// File: tb/tb_uart_csr_block.sv
module tb_uart_csr_block;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W = 6;
    localparam int BUS_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic             wr_en = 1'b0;
    logic [BUS_W-1:0] wr_data = '0;
    logic [BUS_W-1:0] rd_data;
    logic [15:0]      hw_set_a = '0, hw_clr_a = '0, hw_set_b = '0, hw_clr_b = '0;
    logic             irq, tx_valid;
    logic [7:0]       tx_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_csr_block #(.IDX_W(IDX_W), .BUS_W(BUS_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .hw_set_a(hw_set_a), .hw_clr_a(hw_clr_a),
        .hw_set_b(hw_set_b), .hw_clr_b(hw_clr_b),
        .irq(irq), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(int idx, logic [31:0] data);
        reg_idx = IDX_W'(idx);
        wr_data = data;
        wr_en   = 1'b1;
        step();
        wr_en   = 1'b0;
    endtask

    task automatic rd(int idx, output logic [31:0] v);
        reg_idx = IDX_W'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic rdchk(string req, int idx, logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic pulse(logic [15:0] sa, logic [15:0] ca, logic [15:0] sb, logic [15:0] cb);
        hw_set_a = sa; hw_clr_a = ca; hw_set_b = sb; hw_clr_b = cb;
        step();
        hw_set_a = '0; hw_clr_a = '0; hw_set_b = '0; hw_clr_b = '0;
    endtask

    task automatic soft_reset();
        wr('h21, 32'h0000_0000);
        step();
    endtask

    task automatic t_reset();
        rdchk("R1 ctl0", 'h20, 32'h0000);
        rdchk("R1 ctl1", 'h21, 32'h0001);
        rdchk("R1 ctl2", 'h22, 32'h0700);
        rdchk("R1 ctl3", 'h23, 32'h0000);
        rdchk("R1 fifo", 'h24, 32'h0801);
        rdchk("R1 staA", 'h25, 32'h6040);
        rdchk("R1 staB", 'h26, 32'h4028);
        rdchk("R1 bmod", 'h2A, 32'h0000);
        rdchk("R1 bcnt", 'h2B, 32'h0004);
        rdchk("R1 ms",   'h2C, 32'h0000);
        rdchk("R1 test", 'h2D, 32'h0060);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_width();
        wr('h22, 32'hABCD_1234);
        rdchk("R2 ctl2 low half", 'h22, 32'h1234);
        wr('h2B, 32'hFFFF_00C3);
        rdchk("R2 bcnt low half", 'h2B, 32'h00C3);
        wr('h24, 32'h8000_0A05);
        rdchk("R2 fifo low half", 'h24, 32'h0A05);
        soft_reset();
    endtask

    task automatic t_w1c();
        pulse(16'hFFFF, 16'h0, 16'hFFFF, 16'h0);
        rdchk("R5 set A all", 'h25, 32'hFFFF);
        rdchk("R5 set B all", 'h26, 32'hFFFF);
        rdchk("R13 test follows B", 'h2D, 32'h0040);
        wr('h25, 32'hFFFF_FFFF);
        rdchk("R3 W1C mask A", 'h25, 32'h624F);
        wr('h26, 32'h0000_FFFF);
        rdchk("R4 W1C mask B", 'h26, 32'h4429);
        soft_reset();
    endtask

    task automatic t_priority();
        hw_set_b = 16'h0002;
        wr('h26, 32'h0002);
        hw_set_b = '0;
        rdchk("R5 set beats W1C", 'h26, 32'h402A);
        pulse(16'h0, 16'h0, 16'h0, 16'h0002);
        rdchk("R6 hw clear B", 'h26, 32'h4028);
        pulse(16'h0, 16'h2000, 16'h0, 16'h0);
        rdchk("R6 hw clear A", 'h25, 32'h4040);
        pulse(16'h0200, 16'h0200, 16'h0, 16'h0);
        rdchk("R6 set beats clear", 'h25, 32'h4240);
        soft_reset();
    endtask

    task automatic t_softreset();
        wr('h23, 32'h0081);
        wr('h2C, 32'h1234);
        wr('h20, 32'h0100);
        wr('h22, 32'h0055);
        wr('h2A, 32'h0077);
        pulse(16'h0010, 16'h0, 16'h8000, 16'h0);
        wr('h21, 32'h0006);
        rdchk("R11 ctl1 forced bit0", 'h21, 32'h0007);
        rdchk("R11 ctl0 reset", 'h20, 32'h0000);
        rdchk("R11 ctl2 reset", 'h22, 32'h0700);
        rdchk("R11 bmod reset", 'h2A, 32'h0000);
        rdchk("R11 staA reset", 'h25, 32'h6040);
        rdchk("R11 staB reset", 'h26, 32'h4028);
        rdchk("R11 ctl3 kept", 'h23, 32'h0081);
        rdchk("R11 ms kept", 'h2C, 32'h1234);
        wr('h23, 32'h0);
        soft_reset();
    endtask

    task automatic t_irq_a();
        wr('h20, 32'h2000);
        chk("R10 irq not yet", 32'(irq), 32'h0);
        step();
        chk("R7 tx ready irq", 32'(irq), 32'h1);
        wr('h20, 32'h0200);
        step();
        chk("R7 rx ready enable without status", 32'(irq), 32'h0);
        pulse(16'h0200, 16'h0, 16'h0, 16'h0);
        chk("R10 irq lags status", 32'(irq), 32'h0);
        step();
        chk("R7 rx ready irq", 32'(irq), 32'h1);
        pulse(16'h0, 16'h0200, 16'h0, 16'h0);
        step();
        chk("R7 rx ready cleared", 32'(irq), 32'h0);
        wr('h20, 32'h0);
    endtask

    task automatic t_irq_b();
        wr('h20, 32'h0040);
        step();
        chk("R8 tx fifo empty irq", 32'(irq), 32'h1);
        wr('h20, 32'h0);
        wr('h23, 32'h0040);
        step();
        chk("R8 ctl3 bit6 does not enable", 32'(irq), 32'h0);
        wr('h23, 32'h0008);
        step();
        chk("R9 tx done irq", 32'(irq), 32'h1);
        wr('h23, 32'h0001);
        step();
        chk("R9 rx data enable idle", 32'(irq), 32'h0);
        pulse(16'h0, 16'h0, 16'h0001, 16'h0);
        step();
        chk("R9 rx data irq", 32'(irq), 32'h1);
        wr('h23, 32'h0002);
        pulse(16'h0, 16'h0, 16'h0002, 16'h0);
        step();
        chk("R9 overrun irq", 32'(irq), 32'h1);
        wr('h26, 32'h0002);
        step();
        chk("R9 overrun cleared", 32'(irq), 32'h0);
        wr('h23, 32'h0080);
        pulse(16'h0, 16'h0, 16'h0080, 16'h0);
        step();
        chk("R9 wake irq", 32'(irq), 32'h1);
        wr('h23, 32'h0004);
        pulse(16'h0, 16'h0, 16'h0004, 16'h0);
        step();
        chk("R9 break not a source", 32'(irq), 32'h0);
        wr('h23, 32'h0);
        soft_reset();
    endtask

    task automatic t_tx();
        wr('h21, 32'h0005);
        wr('h10, 32'h0000_01A5);
        chk("R12 tx_valid", 32'(tx_valid), 32'h1);
        chk("R12 tx_byte", 32'(tx_byte), 32'hA5);
        rdchk("R12 tx ready dropped", 'h25, 32'h4040);
        rdchk("R12 tx done dropped", 'h26, 32'h4020);
        step();
        chk("R12 tx_valid one cycle", 32'(tx_valid), 32'h0);
        rdchk("R12 tx ready back", 'h25, 32'h6040);
        rdchk("R12 tx done back", 'h26, 32'h4028);
        wr('h21, 32'h0001);
        wr('h10, 32'h0000_005A);
        chk("R12 disabled no strobe", 32'(tx_valid), 32'h0);
        chk("R12 disabled byte kept", 32'(tx_byte), 32'hA5);
        rdchk("R12 disabled status kept", 'h25, 32'h6040);
    endtask

    task automatic t_undef();
        wr('h20, 32'h0100);
        rdchk("R13 undefined read", 'h05, 32'h0);
        rdchk("R13 undefined read 0x29", 'h29, 32'h0);
        wr('h05, 32'hFFFF_FFFF);
        wr('h29, 32'hFFFF_FFFF);
        rdchk("R13 undefined write ctl0", 'h20, 32'h0100);
        rdchk("R13 undefined write ctl1", 'h21, 32'h0001);
        rdchk("R13 undefined write bcnt", 'h2B, 32'h0004);
        wr('h2D, 32'h0000_FFFF);
        rdchk("R13 test read-only", 'h2D, 32'h0060);
        wr('h20, 32'h0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_width();
        t_w1c();
        t_priority();
        t_softreset();
        t_irq_a();
        t_irq_b();
        t_tx();
        t_undef();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule